// File: doc/BRIEF.md
# Processor Bus Hold Arbiter

This block sits beside a processor core on a bus that an external DMA master can take over. Each clock it samples a takeover request and ranks it against the functional reset and the two interrupt inputs. Reset always wins. A takeover request beats both the maskable and the non-maskable interrupt.

When a takeover is recognised, the block first lets any bus cycle in progress finish. It then stops the core's instruction sequencer and releases the bus drivers. Only one clock after that does it raise the grant. When the request goes away, the grant drops first, and the drivers come back one clock later.

Interrupt requests that arrive while the bus is given away are latched. They are serviced once the core owns the bus again. Each service is a one-clock strobe, with the non-maskable request first.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While `rst` is high, `hold_ack` and `bus_oe` are 0, `core_stall` is 1 and both service strobes are 0. In the first cycle after release, `bus_oe` is 1 and `core_stall` is 0.
- R2: A takeover request is recognised only on a clock where `cyc_done` is 1. Before that, the block waits with `core_stall`=1, `bus_oe`=1 and `hold_ack`=0.
- R3: On the edge that recognises the request, `bus_oe` goes to 0 with `hold_ack` still 0. `hold_ack` rises on the following edge.
- R4: `hold_ack` stays 1 and `bus_oe` stays 0 for as long as `hold_req` is sampled high.
- R5: On the edge that samples `hold_req` low during the grant, `hold_ack` falls while `bus_oe` remains 0. On the next edge, `bus_oe` returns to 1 and `core_stall` returns to 0.
- R6: A service strobe (`intr_svc`, `nmi_svc`) is only given while the core runs and `hold_req` is low. A takeover request present in the same cycle defers the service.
- R7: A rising edge on `intr` or `nmi` is latched as pending. The pending request is serviced by a one-clock strobe once the core runs. When both are pending, `nmi_svc` comes one cycle before `intr_svc`.
- R8: Raising `rst` during a grant drops `hold_ack` in the same cycle, without waiting for a clock edge. `bus_oe` stays 0 until `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Functional reset, active high, highest priority |
| hold_req | input | 1 | Bus takeover request from the DMA master |
| intr | input | 1 | Maskable interrupt request (rising edge latched) |
| nmi | input | 1 | Non-maskable interrupt request (rising edge latched) |
| cyc_done | input | 1 | High on the clock that ends the current bus cycle |
| hold_ack | output | 1 | Bus grant to the DMA master |
| bus_oe | output | 1 | Enable for the processor's address, data and control drivers |
| core_stall | output | 1 | Stops the core's instruction sequencer |
| intr_svc | output | 1 | One-clock maskable interrupt service strobe |
| nmi_svc | output | 1 | One-clock non-maskable interrupt service strobe |

## Verification
The assertions take two things for granted:
- the inputs change only between clock edges;
- `rst` is high on the first edge.

The bench meets both conditions by driving every input one time unit after a rising edge and by holding reset from time zero. The assertions also assume that a recognised takeover runs through the whole grant sequence. For that reason, the stimulus never drops `hold_req` before `hold_ack` has been seen. Interrupt inputs are given as single-clock pulses so that each pulse produces exactly one latched edge.

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic intr,
  input  logic nmi,
  input  logic cyc_done,
  output logic hold_ack,
  output logic bus_oe,
  output logic core_stall,
  output logic intr_svc,
  output logic nmi_svc
);

  typedef enum logic [2:0] {S_RUN, S_DRAIN, S_FLOAT, S_GRANT, S_RETURN} st_t;

  st_t  st, st_nx;
  logic intr_q, nmi_q;
  logic intr_pend, nmi_pend;

  always_comb begin
    st_nx = st;
    case (st)
      S_RUN:    if (hold_req) st_nx = cyc_done ? S_FLOAT : S_DRAIN;
      S_DRAIN:  if (cyc_done) st_nx = S_FLOAT;
      S_FLOAT:  st_nx = S_GRANT;
      S_GRANT:  if (!hold_req) st_nx = S_RETURN;
      S_RETURN: st_nx = S_RUN;
      default:  st_nx = S_RUN;
    endcase
  end

  wire running = (st == S_RUN) && !rst;

  assign hold_ack   = (st == S_GRANT) && !rst;
  assign bus_oe     = !rst && (st == S_RUN || st == S_DRAIN);
  assign core_stall = rst || (st != S_RUN);
  assign nmi_svc    = running && !hold_req && nmi_pend;
  assign intr_svc   = running && !hold_req && !nmi_pend && intr_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_RUN;
      intr_q    <= 1'b0;
      nmi_q     <= 1'b0;
      intr_pend <= 1'b0;
      nmi_pend  <= 1'b0;
    end else begin
      st        <= st_nx;
      intr_q    <= intr;
      nmi_q     <= nmi;
      intr_pend <= (intr_pend && !intr_svc) || (intr && !intr_q);
      nmi_pend  <= (nmi_pend && !nmi_svc) || (nmi && !nmi_q);
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |-> (!hold_ack && !bus_oe && core_stall && !intr_svc && !nmi_svc));

  p_release_at_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_oe) |-> $past(cyc_done) && $past(hold_req));

  p_float_before_grant_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(!bus_oe) && !bus_oe);

  p_grant_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && hold_req) |=> hold_ack);

  p_return_order_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack) |-> !bus_oe);

  p_return_next_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack) |=> bus_oe);

  p_hold_beats_irq_r6: assert property (@(posedge clk) disable iff (rst)
    (intr_svc || nmi_svc) |-> (!hold_req && !core_stall && bus_oe));

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({intr_svc, nmi_svc}));

endmodule

// File: tb/sim_bus_hold_arbiter.sv
module sim_bus_hold_arbiter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_req = 1'b0, intr = 1'b0, nmi = 1'b0, cyc_done = 1'b1;
  logic hold_ack, bus_oe, core_stall, intr_svc, nmi_svc;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bus_hold_arbiter u0 (
    .clk(clk), .rst(rst), .hold_req(hold_req), .intr(intr), .nmi(nmi),
    .cyc_done(cyc_done), .hold_ack(hold_ack), .bus_oe(bus_oe),
    .core_stall(core_stall), .intr_svc(intr_svc), .nmi_svc(nmi_svc));

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_out(string req, logic ack, logic oe, logic stall, logic isv, logic nsv);
    chk(req, "hold_ack", hold_ack, ack);
    chk(req, "bus_oe", bus_oe, oe);
    chk(req, "core_stall", core_stall, stall);
    chk(req, "intr_svc", intr_svc, isv);
    chk(req, "nmi_svc", nmi_svc, nsv);
  endtask

  // Drives a takeover with cyc_done high and stops once the grant is seen.
  task automatic go_grant();
    hold_req = 1'b1; cyc_done = 1'b1;
    step(); step();
  endtask

  task automatic t_reset();
    step(2);
    chk_out("R1", 0, 0, 1, 0, 0);
    rst = 1'b0;
    step();
    chk_out("R1", 0, 1, 0, 0, 0);
  endtask

  task automatic t_hold_idle();
    hold_req = 1'b1; cyc_done = 1'b1;
    step();
    chk_out("R3", 0, 0, 1, 0, 0);
    step();
    chk_out("R3", 1, 0, 1, 0, 0);
    step(3);
    chk_out("R4", 1, 0, 1, 0, 0);
    hold_req = 1'b0;
    step();
    chk_out("R5", 0, 0, 1, 0, 0);
    step();
    chk_out("R5", 0, 1, 0, 0, 0);
  endtask

  task automatic t_hold_busy();
    hold_req = 1'b1; cyc_done = 1'b0;
    step();
    chk_out("R2", 0, 1, 1, 0, 0);
    step(2);
    chk_out("R2", 0, 1, 1, 0, 0);
    cyc_done = 1'b1;
    step();
    chk_out("R2", 0, 0, 1, 0, 0);
    step();
    chk_out("R3", 1, 0, 1, 0, 0);
    hold_req = 1'b0;
    step(2);
    chk_out("R5", 0, 1, 0, 0, 0);
  endtask

  task automatic t_irq_plain();
    intr = 1'b1;
    step();
    intr = 1'b0;
    chk_out("R7", 0, 1, 0, 1, 0);
    step();
    chk_out("R7", 0, 1, 0, 0, 0);
  endtask

  task automatic t_irq_in_hold();
    go_grant();
    intr = 1'b1;
    step();
    intr = 1'b0;
    chk_out("R6", 1, 0, 1, 0, 0);
    step(2);
    hold_req = 1'b0;
    step();
    chk_out("R6", 0, 0, 1, 0, 0);
    step();
    chk_out("R7", 0, 1, 0, 1, 0);
    step();
    chk_out("R7", 0, 1, 0, 0, 0);
  endtask

  task automatic t_both_irq();
    go_grant();
    intr = 1'b1; nmi = 1'b1;
    step();
    intr = 1'b0; nmi = 1'b0;
    hold_req = 1'b0;
    step(2);
    chk_out("R7", 0, 1, 0, 0, 1);
    step();
    chk_out("R7", 0, 1, 0, 1, 0);
    step();
    chk_out("R7", 0, 1, 0, 0, 0);
  endtask

  task automatic t_hold_beats_irq();
    intr = 1'b1; hold_req = 1'b1; cyc_done = 1'b1;
    chk("R6", "intr_svc with hold_req high", intr_svc, 1'b0);
    step();
    intr = 1'b0;
    chk_out("R6", 0, 0, 1, 0, 0);
    step();
    hold_req = 1'b0;
    step(2);
    chk_out("R6", 0, 1, 0, 1, 0);
    step();
  endtask

  task automatic t_reset_in_hold();
    go_grant();
    chk("R8", "hold_ack before reset", hold_ack, 1'b1);
    rst = 1'b1;
    #1;
    chk_out("R8", 0, 0, 1, 0, 0);
    step(2);
    chk_out("R8", 0, 0, 1, 0, 0);
    hold_req = 1'b0; rst = 1'b0;
    #1;
    chk_out("R8", 0, 1, 0, 0, 0);
    step();
    chk_out("R1", 0, 1, 0, 0, 0);
  endtask

  initial begin
    #1;
    t_reset();
    t_hold_idle();
    t_hold_busy();
    t_irq_plain();
    t_irq_in_hold();
    t_both_irq();
    t_hold_beats_irq();
    t_reset_in_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule